// File: doc/BRIEF.md
# Half-Bridge Dead-Band Gate Controller

This block turns one PWM command into a pair of complementary gate enables for a half-bridge: a high-side enable that follows the command in phase and a low-side enable that is its complement. Whenever the bridge changes from one switch to the other, both enables are held low for a programmable number of clock cycles. The same count is used in both directions, so the two dead bands match.

Protection inputs sit on top of the PWM path. An active-low shutdown level and a flag reporting that the shutdown pin is undriven each force both enables low. A logic-supply-good flag also disables both enables. A high-side-supply-good flag disables only the high-side enable, and the low side keeps switching. Every asynchronous input passes through a two-flop synchronizer. Both enables then go through the same fixed output pipeline, so turn-on and turn-off latencies match between the two channels.

Top module: `hb_deadband_ctrl`

## Requirements
- R1: `hs_en` follows `pwm_in` in phase and `ls_en` follows its inverse. A change on `pwm_in` first turns the old side off 3 + PIPE_STAGES rising edges after the edge that samples it (two synchronizer flops, one state flop, PIPE_STAGES output flops).
- R2: At every change of side, both enables are low for exactly the effective dead time, counted in clock cycles, before the incoming side is enabled.
- R3: The effective dead time is `dt_cycles` clamped to the range MIN_DT..MAX_DT (default 54..270 cycles, which is 540 ns..2.7 us at 100 MHz). The same value applies to high-to-low and low-to-high changes.
- R4: While the synchronized `sd_n` is 0, both enables are low. Once it returns to 1, normal switching resumes.
- R5: While the synchronized `sd_open` is 1 (shutdown pin undriven), both enables are low.
- R6: While the synchronized `vlog_ok` is 0, both enables are low.
- R7: While the synchronized `vhs_ok` is 0, `hs_en` is low and `ls_en` keeps following the inverse of `pwm_in`.
- R8: After any condition that forced the requested side off has cleared, that side is enabled only after the full effective dead time has elapsed with both enables low.
- R9: Both enables pass through the same PIPE_STAGES-deep register pipeline. Turn-off latency is therefore equal on both channels, and turn-on latency equals turn-off latency plus the dead time.
- R10: `hs_en` and `ls_en` are never high in the same cycle.
- R11: During and right after synchronous reset, both enables are low, and the first enable follows only after a full dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command, 1 selects the high side |
| sd_n | input | 1 | Shutdown level, 0 disables both outputs |
| sd_open | input | 1 | 1 when the shutdown pin is sensed undriven |
| dt_cycles | input | DT_W | Requested dead time in clock cycles |
| vlog_ok | input | 1 | Logic supply good, already carrying hysteresis |
| vhs_ok | input | 1 | Floating high-side supply good |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
A behavioural reference model is compared with both enables on every clock. It is driven first with slow square-wave PWM, which separates correct phase, latency and dead-band length from off-by-one counting errors. Requested dead times below the minimum and above the maximum show whether the clamp is applied in both directions. Fast PWM with pulses shorter than the dead band shows how pending changes collapse while both sides are off. Shutdown, the undriven-pin flag and each supply flag are then asserted during active switching, which separates the whole-bridge lockout from the high-side-only lockout and shows the restart dead band after release.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_HI  = 2'd1,
    DRV_LO  = 2'd2
  } drv_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned SYNC_BITS   = 5;
  localparam int unsigned IDX_PWM  = 0;
  localparam int unsigned IDX_SDN  = 1;
  localparam int unsigned IDX_OPEN = 2;
  localparam int unsigned IDX_VLOG = 3;
  localparam int unsigned IDX_VHS  = 4;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/hb_dt_clamp.sv
module hb_dt_clamp #(
  parameter int unsigned DT_W   = 9,
  parameter int unsigned MIN_DT = 54,
  parameter int unsigned MAX_DT = 270
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DT_W-1:0] dt_req,
  output logic [DT_W-1:0] dt_eff
);
  localparam logic [DT_W-1:0] LO_LIM = DT_W'(MIN_DT);
  localparam logic [DT_W-1:0] HI_LIM = DT_W'(MAX_DT);

  logic [DT_W-1:0] dt_next;

  always_comb begin
    if (dt_req < LO_LIM)      dt_next = LO_LIM;
    else if (dt_req > HI_LIM) dt_next = HI_LIM;
    else                      dt_next = dt_req;
  end

  always_ff @(posedge clk) begin
    if (rst) dt_eff <= LO_LIM;
    else     dt_eff <= dt_next;
  end

  AST_DT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (dt_eff >= LO_LIM) && (dt_eff <= HI_LIM)); // R3
endmodule

// File: rtl/hb_dead_core.sv
module hb_dead_core
  import hb_pkg::*;
#(
  parameter int unsigned DT_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_s,
  input  logic            sdn_s,
  input  logic            open_s,
  input  logic            vlog_s,
  input  logic            vhs_s,
  input  logic [DT_W-1:0] dt_eff,
  output drv_e            drv_q
);
  logic            block_all;
  drv_e            target;
  logic [DT_W-1:0] cnt_q;
  logic            gap_done;

  always_comb begin
    block_all = !sdn_s || open_s || !vlog_s;
    if (block_all)  target = DRV_OFF;
    else if (pwm_s) target = vhs_s ? DRV_HI : DRV_OFF;
    else            target = DRV_LO;
  end

  assign gap_done = (cnt_q >= (dt_eff - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= DRV_OFF;
      cnt_q <= '0;
    end else if (target == DRV_OFF) begin
      drv_q <= DRV_OFF;
      cnt_q <= '0;
    end else if (drv_q == DRV_OFF) begin
      if (gap_done) begin
        drv_q <= target;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (drv_q != target) begin
      drv_q <= DRV_OFF;
      cnt_q <= '0;
    end
  end

  // independent run-length of the all-off state, used only by the checks
  logic [DT_W-1:0] off_seen_q;
  always_ff @(posedge clk) begin
    if (rst) off_seen_q <= '0;
    else if (drv_q != DRV_OFF) off_seen_q <= '0;
    else if (off_seen_q != '1) off_seen_q <= off_seen_q + 1'b1;
  end

  AST_GAP_BEFORE_ON: assert property (@(posedge clk) disable iff (rst)
    (drv_q != DRV_OFF && $past(drv_q) == DRV_OFF) |-> (off_seen_q >= $past(dt_eff))); // R2
  AST_LEAVE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (drv_q != DRV_OFF && target != drv_q) |=> (drv_q == DRV_OFF)); // R1
  AST_BLOCK_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    block_all |=> (drv_q == DRV_OFF)); // R6
  AST_HS_FAULT: assert property (@(posedge clk) disable iff (rst)
    !vhs_s |=> (drv_q != DRV_HI)); // R7
endmodule

// File: rtl/hb_out_pipe.sv
module hb_out_pipe #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_d,
  input  logic ls_d,
  output logic hs_q,
  output logic ls_q
);
  logic [1:0] pipe_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe_q[s] <= 2'b00;
        else if (s == 0) pipe_q[s] <= {hs_d, ls_d};
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign hs_q = pipe_q[STAGES-1][1];
  assign ls_q = pipe_q[STAGES-1][0];
endmodule

// File: rtl/hb_deadband_ctrl.sv
module hb_deadband_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned MIN_DT      = 54,
  parameter int unsigned MAX_DT      = 270,
  parameter int unsigned PIPE_STAGES = 2,
  parameter int unsigned DT_W        = $clog2(MAX_DT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_in,
  input  logic            sd_n,
  input  logic            sd_open,
  input  logic [DT_W-1:0] dt_cycles,
  input  logic            vlog_ok,
  input  logic            vhs_ok,
  output logic            hs_en,
  output logic            ls_en
);
  logic [SYNC_BITS-1:0] raw_in;
  logic [SYNC_BITS-1:0] syn;
  logic [DT_W-1:0]      dt_eff;
  drv_e                 drv;

  always_comb begin
    raw_in           = '0;
    raw_in[IDX_PWM]  = pwm_in;
    raw_in[IDX_SDN]  = sd_n;
    raw_in[IDX_OPEN] = sd_open;
    raw_in[IDX_VLOG] = vlog_ok;
    raw_in[IDX_VHS]  = vhs_ok;
  end

  hb_sync #(.WIDTH(SYNC_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_in), .q_sync(syn)
  );

  hb_dt_clamp #(.DT_W(DT_W), .MIN_DT(MIN_DT), .MAX_DT(MAX_DT)) u_clamp (
    .clk(clk), .rst(rst), .dt_req(dt_cycles), .dt_eff(dt_eff)
  );

  hb_dead_core #(.DT_W(DT_W)) u_core (
    .clk(clk), .rst(rst),
    .pwm_s(syn[IDX_PWM]), .sdn_s(syn[IDX_SDN]), .open_s(syn[IDX_OPEN]),
    .vlog_s(syn[IDX_VLOG]), .vhs_s(syn[IDX_VHS]),
    .dt_eff(dt_eff), .drv_q(drv)
  );

  hb_out_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
    .clk(clk), .rst(rst),
    .hs_d(drv == DRV_HI), .ls_d(drv == DRV_LO),
    .hs_q(hs_en), .ls_q(ls_en)
  );

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en)); // R10
  AST_RESET_OFF: assert property (@(posedge clk)
    rst |=> (!hs_en && !ls_en)); // R11
endmodule

// File: tb/hb_deadband_ctrl_bench.sv
module hb_deadband_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_DT = 54;
  localparam int MAX_DT = 270;
  localparam int PIPE = 2;
  localparam int DT_W = 9;

  logic clk = 0, rst = 1;
  logic pwm_in = 0, sd_n = 1, sd_open = 0, vlog_ok = 1, vhs_ok = 1;
  logic [DT_W-1:0] dt_cycles = 9'd60;
  logic hs_en, ls_en;

  int checks = 0, fails = 0, cycles = 0;
  string req = "R11";

  hb_deadband_ctrl #(.MIN_DT(MIN_DT), .MAX_DT(MAX_DT), .PIPE_STAGES(PIPE)) u_hb_deadband_ctrl (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .sd_n(sd_n), .sd_open(sd_open),
    .dt_cycles(dt_cycles), .vlog_ok(vlog_ok), .vhs_ok(vhs_ok),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_s1 [5];
  int m_s2 [5];
  int m_dt, m_side, m_wait;
  int m_hs [$];
  int m_ls [$];
  int exp_hs, exp_ls;

  initial begin
    for (int i = 0; i < 5; i++) begin m_s1[i] = 0; m_s2[i] = 0; end
    m_dt = MIN_DT; m_side = 0; m_wait = 0;
    for (int i = 0; i < PIPE; i++) begin m_hs.push_back(0); m_ls.push_back(0); end
    exp_hs = 0; exp_ls = 0;
  end

  always @(posedge clk) begin
    int want;
    int req_dt;
    if (rst) begin
      for (int i = 0; i < 5; i++) begin m_s1[i] = 0; m_s2[i] = 0; end
      m_dt = MIN_DT; m_side = 0; m_wait = 0;
      for (int i = 0; i < PIPE; i++) begin m_hs[i] = 0; m_ls[i] = 0; end
    end else begin
      void'(m_hs.pop_back()); void'(m_ls.pop_back());
      m_hs.push_front(m_side == 1 ? 1 : 0);
      m_ls.push_front(m_side == 2 ? 1 : 0);
      if (m_s2[1] == 0 || m_s2[2] == 1 || m_s2[3] == 0) want = 0;
      else if (m_s2[0] == 1) want = (m_s2[4] == 1) ? 1 : 0;
      else want = 2;
      if (want == 0) begin m_side = 0; m_wait = 0; end
      else if (m_side == 0) begin
        if (m_wait + 1 >= m_dt) begin m_side = want; m_wait = 0; end
        else m_wait++;
      end else if (m_side != want) begin m_side = 0; m_wait = 0; end
      req_dt = int'(dt_cycles);
      m_dt = (req_dt < MIN_DT) ? MIN_DT : (req_dt > MAX_DT) ? MAX_DT : req_dt;
      m_s2 = m_s1;
      m_s1[0] = int'(pwm_in); m_s1[1] = int'(sd_n); m_s1[2] = int'(sd_open);
      m_s1[3] = int'(vlog_ok); m_s1[4] = int'(vhs_ok);
    end
    exp_hs = m_hs[PIPE-1];
    exp_ls = m_ls[PIPE-1];
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    checks++;
    if (int'(hs_en) != exp_hs || int'(ls_en) != exp_ls) begin
      fails++;
      $display("FAIL %s cycle %0d: hs/ls actual %0d%0d expected %0d%0d",
               req, cycles, hs_en, ls_en, exp_hs, exp_ls);
    end
    checks++;
    if (hs_en && ls_en) begin // R10
      fails++;
      $display("FAIL R10 cycle %0d: actual both high, expected at most one", cycles);
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_bit(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, expv);
    end
  endtask

  // change side and measure the all-off gap seen at the outputs
  task automatic swap_gap(logic lvl, int exp_gap, string tag);
    int n;
    pwm_in = lvl;
    n = 0;
    while ((hs_en || ls_en) && n < 40) begin @(negedge clk); n++; end
    n = 0;
    while (!(lvl ? hs_en : ls_en) && n < 1000) begin n++; @(negedge clk); end
    checks++;
    if (n != exp_gap) begin
      fails++;
      $display("FAIL %s: dead gap actual %0d expected %0d", tag, n, exp_gap);
    end
    wait_cyc(100);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    check_bit("R11 reset hs", hs_en, 1'b0);
    check_bit("R11 reset ls", ls_en, 1'b0);
    rst = 0;
    wait_cyc(2);
    check_bit("R11 post-reset ls still off", ls_en, 1'b0);

    req = "R1";
    wait_cyc(100);
    check_bit("R1 low side follows inverse", ls_en, 1'b1);
    swap_gap(1'b1, 60, "R2 low-to-high");
    check_bit("R1 high side in phase", hs_en, 1'b1);
    swap_gap(1'b0, 60, "R2 high-to-low");

    req = "R3";
    dt_cycles = 9'd5;
    wait_cyc(10);
    swap_gap(1'b1, MIN_DT, "R3 clamp low L->H");
    swap_gap(1'b0, MIN_DT, "R3 clamp low H->L");
    dt_cycles = 9'd400;
    wait_cyc(10);
    swap_gap(1'b1, MAX_DT, "R3 clamp high L->H");
    swap_gap(1'b0, MAX_DT, "R3 clamp high H->L");
    wait_cyc(300);

    req = "R9";
    dt_cycles = 9'd60;
    wait_cyc(10);
    for (int k = 0; k < 12; k++) begin pwm_in = ~pwm_in; wait_cyc(20); end
    pwm_in = 1'b1;
    wait_cyc(200);

    req = "R4";
    sd_n = 1'b0;
    wait_cyc(20);
    check_bit("R4 shutdown hs", hs_en, 1'b0);
    check_bit("R4 shutdown ls", ls_en, 1'b0);
    sd_n = 1'b1;
    req = "R8";
    wait_cyc(40);
    check_bit("R8 restart waits dead time", hs_en, 1'b0);
    wait_cyc(100);
    check_bit("R4 resumed", hs_en, 1'b1);

    req = "R5";
    sd_open = 1'b1;
    wait_cyc(20);
    check_bit("R5 undriven pin hs", hs_en, 1'b0);
    pwm_in = 1'b0;
    wait_cyc(100);
    check_bit("R5 undriven pin ls", ls_en, 1'b0);
    sd_open = 1'b0;
    wait_cyc(150);

    req = "R6";
    vlog_ok = 1'b0;
    wait_cyc(20);
    check_bit("R6 logic supply ls", ls_en, 1'b0);
    pwm_in = 1'b1;
    wait_cyc(100);
    check_bit("R6 logic supply hs", hs_en, 1'b0);
    vlog_ok = 1'b1;
    wait_cyc(150);

    req = "R7";
    vhs_ok = 1'b0;
    wait_cyc(20);
    check_bit("R7 high-side fault hs", hs_en, 1'b0);
    pwm_in = 1'b0;
    wait_cyc(100);
    check_bit("R7 low side keeps running", ls_en, 1'b1);
    pwm_in = 1'b1;
    wait_cyc(100);
    check_bit("R7 hs still blocked", hs_en, 1'b0);
    vhs_ok = 1'b1;
    wait_cyc(150);
    check_bit("R7 hs back after recovery", hs_en, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule